// File: doc/BRIEF.md
# Execution-Origin Peripheral Access Gate

This block sits on a small register bus in front of a serial-peripheral master. It decides, cycle by cycle, whether the processor may use that peripheral. The decision comes from where the processor is currently fetching instructions. Two single-cycle indications report whether the most recent instruction fetch came from on-chip ROM or from RAM. A fetch from ROM grants the right to use the peripheral. A fetch from RAM takes that right away. Firmware in ROM can therefore drive the peripheral, and code loaded into RAM cannot.

While the right is withheld, every read of a peripheral register returns zero and every write to one is discarded. Registers outside the peripheral group, an identification word and a scratch word, answer normally whatever the state of the right. Reads are combinational on chip-select with write-enable low. The peripheral's shift engine is replaced by a busy counter, which gives a realistic ready indication.

Top module: `exec_origin_spi_gate`

## Requirements
- R1: While reset is active and after it is released, the grant flag is clear. A read of the transfer/ready register (word address 0x21, bit 0) then returns 0.
- R2: A one-cycle pulse on `rom_fetch` sets the grant on the next rising clock edge. From then on, a read of address 0x21 returns 1 while the peripheral is idle.
- R3: A one-cycle pulse on `ram_fetch` clears the grant on the next rising clock edge. From then on, a read of address 0x21 returns 0.
- R4: After being cleared by a RAM pulse, the grant is set again by a later ROM pulse.
- R5: In cycles where neither fetch input is high, the grant keeps its value.
- R6: If `rom_fetch` and `ram_fetch` are high in the same cycle, the grant ends up clear.
- R7: While the grant is clear, writes to the enable register (0x20, bit 0), the transfer register (0x21, any write starts a transfer) and the data register (0x22, low `SPI_DW` bits) change nothing. After a later grant, these registers read back their reset values 0, 1 (idle) and 0.
- R8: While the grant is clear, reads of 0x20, 0x21 and 0x22 return 0, even if those registers hold non-zero values.
- R9: The identification word at 0x00 reads as `ID_WORD`, and the scratch word at 0x01 is writable and readable, regardless of the grant.
- R10: A granted write to 0x21 while enable is 1 and the peripheral is idle makes the ready bit read 0 for exactly `XFER_CYCLES` rising edges, starting with the write edge. The bit reads 1 afterwards.
- R11: When `cs` is low, or `we` is high, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rom_fetch | input | 1 | Single-cycle pulse: last instruction fetch came from ROM |
| ram_fetch | input | 1 | Single-cycle pulse: last instruction fetch came from RAM |
| cs | input | 1 | Register chip-select |
| we | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational |

## Verification
The hardest state to reach is a blocked grant while the peripheral registers hold non-zero values. Writes cannot load them while blocked, so the bench grants access and loads enable and data. It then revokes with a RAM pulse and shows that reads return zero. It re-grants to show that the values survived. The simultaneous-pulse case takes deliberate alignment: both inputs are raised in the same cycle after a grant, so that a wrong priority would leave the flag set.

// File: rtl/gate_pkg.sv
package gate_pkg;

  localparam logic [7:0] A_ID      = 8'h00;
  localparam logic [7:0] A_SCRATCH = 8'h01;
  localparam logic [7:0] A_SPI_EN  = 8'h20;
  localparam logic [7:0] A_SPI_XFR = 8'h21;
  localparam logic [7:0] A_SPI_DAT = 8'h22;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_SCRATCH,
    SEL_SPI_EN,
    SEL_SPI_XFR,
    SEL_SPI_DAT
  } rd_sel_e;

  typedef struct packed {
    logic scratch;
    logic spi_en;
    logic spi_xfr;
    logic spi_dat;
  } wr_strobe_t;

endpackage

// File: rtl/origin_perm.sv
module origin_perm (
  input  logic clk,
  input  logic rst_n,
  input  logic rom_fetch,
  input  logic ram_fetch,
  output logic granted
);

  logic granted_q;
  logic granted_d;

  // RAM activity has priority so a collision fails safe.
  always_comb begin
    granted_d = granted_q;
    if (ram_fetch) begin
      granted_d = 1'b0;
    end else if (rom_fetch) begin
      granted_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted_q <= 1'b0;
    end else begin
      granted_q <= granted_d;
    end
  end

  assign granted = granted_q;

endmodule

// File: rtl/gate_decode.sv
module gate_decode
  import gate_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              granted,
  output wr_strobe_t        wr,
  output rd_sel_e           rd_sel
);

  logic [7:0] a8;
  logic       spi_grp;

  assign a8      = 8'(addr);
  assign spi_grp = (a8 == A_SPI_EN) || (a8 == A_SPI_XFR) || (a8 == A_SPI_DAT);

  always_comb begin
    wr = '0;
    if (cs && we) begin
      wr.scratch = (a8 == A_SCRATCH);
      wr.spi_en  = granted && (a8 == A_SPI_EN);
      wr.spi_xfr = granted && (a8 == A_SPI_XFR);
      wr.spi_dat = granted && (a8 == A_SPI_DAT);
    end
  end

  always_comb begin
    rd_sel = SEL_NONE;
    if (cs && !we) begin
      if (a8 == A_ID) begin
        rd_sel = SEL_ID;
      end else if (a8 == A_SCRATCH) begin
        rd_sel = SEL_SCRATCH;
      end else if (spi_grp && granted) begin
        case (a8)
          A_SPI_EN:  rd_sel = SEL_SPI_EN;
          A_SPI_XFR: rd_sel = SEL_SPI_XFR;
          default:   rd_sel = SEL_SPI_DAT;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_stub.sv
module spi_stub #(
  parameter int SPI_DW      = 8,
  parameter int XFER_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_xfr,
  input  logic              wr_dat,
  input  logic [SPI_DW-1:0] wval,
  output logic              enable,
  output logic [SPI_DW-1:0] txdata,
  output logic              ready
);

  localparam int CNT_W = $clog2(XFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_CYCLES);

  logic              en_q;
  logic [SPI_DW-1:0] dat_q;
  logic [CNT_W-1:0]  busy_q, busy_d;
  logic              start;

  assign ready = (busy_q == '0);
  assign start = wr_xfr && en_q && ready;

  always_comb begin
    busy_d = busy_q;
    if (start) begin
      busy_d = CNT_LOAD;
    end else if (!ready) begin
      busy_d = busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dat_q  <= '0;
      busy_q <= '0;
    end else begin
      if (wr_en) begin
        en_q <= wval[0];
      end
      if (wr_dat) begin
        dat_q <= wval;
      end
      busy_q <= busy_d;
    end
  end

  assign enable = en_q;
  assign txdata = dat_q;

endmodule

// File: rtl/exec_origin_spi_gate.sv
module exec_origin_spi_gate
  import gate_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          SPI_DW      = 8,
  parameter int          XFER_CYCLES = 8,
  parameter logic [31:0] ID_WORD     = 32'h6f72_6731
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_fetch,
  input  logic              ram_fetch,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic              rst_meta, rst_ok;
  logic              granted;
  wr_strobe_t        wr;
  rd_sel_e           rd_sel;
  logic              spi_enable, spi_ready;
  logic [SPI_DW-1:0] spi_txdata;
  logic [DATA_W-1:0] scratch_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  origin_perm u_perm (
    .clk       (clk),
    .rst_n     (rst_ok),
    .rom_fetch (rom_fetch),
    .ram_fetch (ram_fetch),
    .granted   (granted)
  );

  gate_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs      (cs),
    .we      (we),
    .addr    (addr),
    .granted (granted),
    .wr      (wr),
    .rd_sel  (rd_sel)
  );

  spi_stub #(.SPI_DW(SPI_DW), .XFER_CYCLES(XFER_CYCLES)) u_spi (
    .clk    (clk),
    .rst_n  (rst_ok),
    .wr_en  (wr.spi_en),
    .wr_xfr (wr.spi_xfr),
    .wr_dat (wr.spi_dat),
    .wval   (wdata[SPI_DW-1:0]),
    .enable (spi_enable),
    .txdata (spi_txdata),
    .ready  (spi_ready)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      scratch_q <= '0;
    end else if (wr.scratch) begin
      scratch_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (rd_sel)
      SEL_ID:      rdata = DATA_W'(ID_WORD);
      SEL_SCRATCH: rdata = scratch_q;
      SEL_SPI_EN:  rdata = DATA_W'(spi_enable);
      SEL_SPI_XFR: rdata = DATA_W'(spi_ready);
      SEL_SPI_DAT: rdata = DATA_W'(spi_txdata);
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/exec_origin_spi_gate_chk.sv
module exec_origin_spi_gate_chk #(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_WORD = 32'h0
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              rom_fetch,
  input logic              ram_fetch,
  input logic              granted,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata
);

  always @(posedge clk) begin
    if (!rst_ok) begin
      AST_RESET_BLOCKED: assert (granted == 1'b0); // R1
    end
  end

  AST_ROM_GRANTS: assert property (@(posedge clk) disable iff (!rst_ok)
    (rom_fetch && !ram_fetch) |=> granted); // R2

  AST_RAM_REVOKES: assert property (@(posedge clk) disable iff (!rst_ok)
    ram_fetch |=> !granted); // R3

  AST_BOTH_FAIL_SAFE: assert property (@(posedge clk) disable iff (!rst_ok)
    (rom_fetch && ram_fetch) |=> !granted); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (!rom_fetch && !ram_fetch) |=> $stable(granted)); // R5

  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (cs && !we && !granted && (8'(addr) inside {8'h20, 8'h21, 8'h22})) |-> (rdata == '0)); // R8

  AST_ID_VISIBLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cs && !we && 8'(addr) == 8'h00) |-> (rdata == DATA_W'(ID_WORD))); // R9

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cs || we) |-> (rdata == '0)); // R11

endmodule

bind exec_origin_spi_gate exec_origin_spi_gate_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ID_WORD (ID_WORD)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .rom_fetch (rom_fetch),
  .ram_fetch (ram_fetch),
  .granted   (granted),
  .cs        (cs),
  .we        (we),
  .addr      (addr),
  .rdata     (rdata)
);

// File: tb/tb_exec_origin_spi_gate.sv
`timescale 1ns/1ps
module tb_exec_origin_spi_gate;

  localparam int          ADDR_W = 8;
  localparam int          DATA_W = 32;
  localparam int          XFERC  = 8;
  localparam logic [31:0] IDW    = 32'h6f72_6731;

  localparam logic [7:0] AID = 8'h00, ASCR = 8'h01, AEN = 8'h20, AXFR = 8'h21, ADAT = 8'h22;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rom_fetch, ram_fetch, cs, we;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] rv;

  always #2.5 clk = ~clk;

  exec_origin_spi_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPI_DW(8),
    .XFER_CYCLES(XFERC), .ID_WORD(IDW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rom_fetch(rom_fetch), .ram_fetch(ram_fetch),
    .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // All tasks start just after a falling edge.
  task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [DATA_W-1:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata;
    cs = 1'b0;
  endtask

  task automatic pulse(input logic rom, input logic ram);
    rom_fetch = rom; ram_fetch = ram;
    @(negedge clk);
    rom_fetch = 1'b0; ram_fetch = 1'b0;
  endtask

  task automatic t_reset;
    rd(AXFR, rv); check("R1 xfer after reset", rv, 32'h0);
  endtask

  task automatic t_blocked_writes;
    wr(AEN, 32'h1);
    wr(ADAT, 32'hA5);
    wr(AXFR, 32'h1);
    pulse(1'b1, 1'b0);
    rd(AEN, rv);  check("R7 enable unchanged", rv, 32'h0);
    rd(ADAT, rv); check("R7 data unchanged", rv, 32'h0);
    rd(AXFR, rv); check("R7 no transfer started", rv, 32'h1);
    pulse(1'b0, 1'b1);
  endtask

  task automatic t_grant;
    pulse(1'b1, 1'b0);
    rd(AXFR, rv); check("R2 grant after rom pulse", rv, 32'h1);
  endtask

  task automatic t_hold;
    repeat (20) @(negedge clk);
    rd(AXFR, rv); check("R5 grant held", rv, 32'h1);
  endtask

  task automatic t_transfer;
    wr(AEN, 32'h1);
    wr(ADAT, 32'h3C);
    rd(AEN, rv);  check("R10 enable readback", rv, 32'h1);
    rd(ADAT, rv); check("R10 data readback", rv, 32'h3C);
    wr(AXFR, 32'h1);
    rd(AXFR, rv); check("R10 busy after start", rv, 32'h0);
    repeat (XFERC - 1) @(negedge clk);
    rd(AXFR, rv); check("R10 busy last cycle", rv, 32'h0);
    @(negedge clk);
    rd(AXFR, rv); check("R10 ready after window", rv, 32'h1);
  endtask

  task automatic t_revoke;
    pulse(1'b0, 1'b1);
    rd(AXFR, rv); check("R3 revoked after ram pulse", rv, 32'h0);
    rd(AEN, rv);  check("R8 enable hidden", rv, 32'h0);
    rd(ADAT, rv); check("R8 data hidden", rv, 32'h0);
    repeat (10) @(negedge clk);
    rd(AXFR, rv); check("R5 block held", rv, 32'h0);
  endtask

  task automatic t_outside;
    rd(AID, rv); check("R9 id while blocked", rv, IDW);
    wr(ASCR, 32'hDEAD_BEEF);
    rd(ASCR, rv); check("R9 scratch while blocked", rv, 32'hDEAD_BEEF);
  endtask

  task automatic t_regrant;
    pulse(1'b1, 1'b0);
    rd(AXFR, rv); check("R4 regrant", rv, 32'h1);
    rd(ADAT, rv); check("R4 data kept across revoke", rv, 32'h3C);
  endtask

  task automatic t_both;
    pulse(1'b1, 1'b1);
    rd(AXFR, rv); check("R6 simultaneous pulses block", rv, 32'h0);
    pulse(1'b1, 1'b0);
    rd(AXFR, rv); check("R6 recovers after rom", rv, 32'h1);
  endtask

  task automatic t_idle_bus;
    cs = 1'b0; we = 1'b0; addr = AXFR; #1;
    check("R11 cs low", rdata, 32'h0);
    cs = 1'b1; we = 1'b1; addr = AID; wdata = '0; #0.5;
    check("R11 write cycle", rdata, 32'h0);
    cs = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; rom_fetch = 1'b0; ram_fetch = 1'b0;
    cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_blocked_writes();
    t_grant();
    t_hold();
    t_transfer();
    t_revoke();
    t_outside();
    t_regrant();
    t_both();
    t_idle_bus();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule